// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block sits between the command decoder of a serial NAND memory and the paths that write the array and the protection register. For each decoded command that changes stored state, it decides in one cycle whether the command may proceed. It raises a one-cycle accept or reject pulse on the cycle after the strobe. It also owns the write-enable latch, the protection register, and the timer that holds back write-class commands after power comes up.

Commands arrive as a plain strobe with no back-pressure. `cmd_vld` is high for one cycle and `cmd_kind` names the class. The verdict appears on `cmd_acc` or `cmd_rej` exactly one clock later, and the block never stalls. `pwr_good` and `wp_n` are asynchronous and pass through two-flop synchronizers, so they take effect two cycles after they change. While the synchronized power indication is low, the block holds its state in reset. This is the only way to clear the register lock.

Top module: `flash_wr_guard`

## Requirements
- R1: While the synchronized `pwr_good` is low, `wel` is 0, `prot_q` is all zero and no strobe produces an accept or reject pulse.
- R2: After the synchronized `pwr_good` rises, a holdoff of `HOLD_CYC` cycles runs, and every gated command is rejected until it ends. A drop of `pwr_good` during the count restarts it from zero.
- R3: `wel` reads 0 after power-up. An accepted write-enable (`cmd_kind`=1) sets it and an accepted write-disable (`cmd_kind`=2) clears it. Both are accepted only after holdoff and while hardware protection is inactive.
- R4: Program-execute (`cmd_kind`=3) and block-erase (`cmd_kind`=4) are accepted only when `wel` is 1.
- R5: A pulse on `op_done` clears `wel`. If an accepted write-enable arrives in the same cycle, `wel` ends at 1.
- R6: When protection-register bit 0 (hardware-protect enable) is 1 and `wp_n` is low, all gated commands (kinds 1 to 5) are rejected and `read_only` is 1.
- R7: `quad_ok` is 0 whenever register bit 0 is 1, whatever the level of `wp_n`.
- R8: When register bit 1 (register guard) is 1 and `wp_n` is low, a register write (`cmd_kind`=5) is rejected even if bit 0 is 0.
- R9: Once register bit 2 (lock) is 1, every register write is rejected until `pwr_good` drops.
- R10: A verdict is a single-cycle pulse on the cycle after the strobe. A reject changes neither `wel` nor the register. Kinds 0, 6 and 7 produce no pulse.
- R11: An accepted register write loads `reg_wdata` whole into the register, and the register is visible on `prot_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above write threshold (asynchronous) |
| wp_n | input | 1 | Write-protect pin, active low (asynchronous) |
| cmd_vld | input | 1 | One-cycle decoded command strobe |
| cmd_kind | input | 3 | Command class: 0 other, 1 wr-enable, 2 wr-disable, 3 program, 4 erase, 5 register write |
| reg_wdata | input | PROT_W | New register value for a register write |
| op_done | input | 1 | Program or erase completion pulse |
| cmd_acc | output | 1 | Command accepted (one cycle) |
| cmd_rej | output | 1 | Command rejected (one cycle) |
| wel | output | 1 | Write-enable latch |
| quad_ok | output | 1 | Four-lane transfers permitted |
| read_only | output | 1 | Hardware protection currently active |
| prot_q | output | PROT_W | Protection register contents |

## Verification
The bench builds the block with `HOLD_CYC` = 16 and `PROT_W` = 8. This keeps the holdoff short enough to cross repeatedly. A power drop partway through the count then leaves a residual count that would have expired early if it were not cleared. With an 8-bit register, the upper block-protect bits can ride along with the lock bit, which shows that the whole word is stored. The two-cycle synchronizer latency on the pin is covered by settling the pin before each strobe.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_WEN   = 3'd1,
    K_WDIS  = 3'd2,
    K_PROG  = 3'd3,
    K_ERASE = 3'd4,
    K_REGWR = 3'd5
  } cmd_kind_e;

  localparam int BIT_HWEN  = 0;
  localparam int BIT_GUARD = 1;
  localparam int BIT_LOCK  = 2;
  localparam int SYNC_LEN  = 2;

  typedef struct packed {
    logic acc;
    logic rej;
    logic wel_set;
    logic wel_clr;
    logic reg_we;
  } verdict_t;

  function automatic logic is_gated(input logic [2:0] k);
    return (k >= 3'd1) && (k <= 3'd5);
  endfunction

endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  import fwg_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [SYNC_LEN-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {SYNC_LEN{rst_val[i]}};
      else        chain <= {chain[SYNC_LEN-2:0], d[i]};
    end
    assign q[i] = chain[SYNC_LEN-1];
  end

endmodule

// File: rtl/fwg_holdoff.sv
module fwg_holdoff #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic ready
);
  localparam int CW = $clog2(HOLD_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!pwr_ok)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  assign ready = pwr_ok && (cnt_q == LIMIT);

  assert_hold_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  assert_hold_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !ready) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  assert_hold_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (cnt_q == '0));

endmodule

// File: rtl/fwg_decide.sv
module fwg_decide (
  input  logic                 vld,
  input  logic [2:0]           kind,
  input  logic                 pwr_ok,
  input  logic                 ready,
  input  logic                 pin_hi,
  input  logic                 hw_en,
  input  logic                 guard,
  input  logic                 lock,
  input  logic                 wel,
  output fwg_pkg::verdict_t    v
);
  import fwg_pkg::*;

  logic hw_block, ok, fire;

  always_comb begin
    hw_block = hw_en && !pin_hi;
    unique case (kind)
      K_WEN, K_WDIS:   ok = !hw_block;
      K_PROG, K_ERASE: ok = !hw_block && wel;
      K_REGWR:         ok = !hw_block && !lock && !(guard && !pin_hi);
      default:         ok = 1'b0;
    endcase
    fire      = vld && pwr_ok && is_gated(kind);
    v.acc     = fire && ready && ok;
    v.rej     = fire && !(ready && ok);
    v.wel_set = v.acc && (kind == K_WEN);
    v.wel_clr = v.acc && (kind == K_WDIS);
    v.reg_we  = v.acc && (kind == K_REGWR);
  end

  always_comb begin
    assert_verdict_excl_R10: assert (!(v.acc && v.rej));
  end

endmodule

// File: rtl/fwg_wel.sv
module fwg_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic set,
  input  logic clr,
  input  logic done,
  output logic wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wel <= 1'b0;
    else if (!pwr_ok) wel <= 1'b0;
    else if (set)     wel <= 1'b1;
    else if (clr || done) wel <= 1'b0;
  end

  assert_wel_off_unpowered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !wel);

  assert_wel_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(set));

  assert_wel_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !set) |=> !wel);

endmodule

// File: rtl/fwg_preg.sv
module fwg_preg #(
  parameter int PROT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              we,
  input  logic [PROT_W-1:0] wdata,
  output logic [PROT_W-1:0] reg_q,
  output logic              hw_en,
  output logic              guard,
  output logic              lock
);
  import fwg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reg_q <= '0;
    else if (!pwr_ok) reg_q <= '0;
    else if (we)      reg_q <= wdata;
  end

  assign hw_en = reg_q[BIT_HWEN];
  assign guard = reg_q[BIT_GUARD];
  assign lock  = reg_q[BIT_LOCK];

  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && pwr_ok) |=> (!pwr_ok || $stable(reg_q)));

  assert_reg_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (reg_q == '0));

endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard #(
  parameter int HOLD_CYC = 1000,
  parameter int PROT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              wp_n,
  input  logic              cmd_vld,
  input  logic [2:0]        cmd_kind,
  input  logic [PROT_W-1:0] reg_wdata,
  input  logic              op_done,
  output logic              cmd_acc,
  output logic              cmd_rej,
  output logic              wel,
  output logic              quad_ok,
  output logic              read_only,
  output logic [PROT_W-1:0] prot_q
);
  import fwg_pkg::*;

  logic [1:0] sync_q;
  logic       pwr_ok, pin_hi, ready;
  logic       hw_en, guard, lock;
  verdict_t   v;

  fwg_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d       ({pwr_good, wp_n}),
    .rst_val (2'b01),
    .q       (sync_q)
  );
  assign pwr_ok = sync_q[1];
  assign pin_hi = sync_q[0];

  fwg_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_ok (pwr_ok),
    .ready  (ready)
  );

  fwg_decide u_dec (
    .vld    (cmd_vld),
    .kind   (cmd_kind),
    .pwr_ok (pwr_ok),
    .ready  (ready),
    .pin_hi (pin_hi),
    .hw_en  (hw_en),
    .guard  (guard),
    .lock   (lock),
    .wel    (wel),
    .v      (v)
  );

  fwg_wel u_wel (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_ok (pwr_ok),
    .set    (v.wel_set),
    .clr    (v.wel_clr),
    .done   (op_done),
    .wel    (wel)
  );

  fwg_preg #(.PROT_W(PROT_W)) u_preg (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_ok (pwr_ok),
    .we     (v.reg_we),
    .wdata  (reg_wdata),
    .reg_q  (prot_q),
    .hw_en  (hw_en),
    .guard  (guard),
    .lock   (lock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_acc <= 1'b0;
      cmd_rej <= 1'b0;
    end else begin
      cmd_acc <= v.acc;
      cmd_rej <= v.rej;
    end
  end

  assign read_only = hw_en && !pin_hi;
  assign quad_ok   = !hw_en;

  assert_pulse_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc || cmd_rej) |-> $past(cmd_vld));

  assert_no_verdict_unpowered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !(cmd_acc || cmd_rej));

  assert_prog_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && ($past(cmd_kind) == K_PROG || $past(cmd_kind) == K_ERASE)) |-> $past(wel));

  assert_hw_block_rejects_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (read_only && pwr_ok && cmd_vld && is_gated(cmd_kind)) |=> cmd_rej);

  assert_quad_off_when_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    read_only |-> !quad_ok);

  assert_holdoff_rejects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && cmd_vld && pwr_ok && is_gated(cmd_kind)) |=> cmd_rej);

endmodule

// File: tb/flash_wr_guard_tb.sv
module flash_wr_guard_tb;

  localparam int HOLD = 16;
  localparam int PW   = 8;
  localparam int NV   = 22;

  // kind[17:15] data[14:7] wp_n[6] done[5] | exp acc[4] rej[3] wel[2] ro[1] quad[0]
  localparam logic [17:0] VEC [NV] = '{
    18'b001_00000000_1_0_1_0_1_0_1, // R3 enable
    18'b010_00000000_1_0_1_0_0_0_1, // R3 disable
    18'b011_00000000_1_0_0_1_0_0_1, // R4 program without latch
    18'b001_00000000_1_0_1_0_1_0_1,
    18'b011_00000000_1_0_1_0_1_0_1, // R4 program with latch
    18'b000_00000000_1_1_0_0_0_0_1, // R5 completion clears
    18'b100_00000000_1_0_0_1_0_0_1, // R4 erase without latch
    18'b001_00000000_1_0_1_0_1_0_1,
    18'b100_00000000_1_0_1_0_1_0_1, // R4 erase with latch
    18'b000_00000000_1_1_0_0_0_0_1, // R5
    18'b001_00000000_1_1_1_0_1_0_1, // R5 enable wins over completion
    18'b101_00000001_1_0_1_0_1_0_0, // R7 hw enable set
    18'b010_00000000_0_0_0_1_1_1_0, // R6 R10 disable blocked, latch kept
    18'b011_00000000_0_0_0_1_1_1_0, // R6
    18'b101_00000000_0_0_0_1_1_1_0, // R6
    18'b001_00000000_1_0_1_0_1_0_0, // R6 pin high releases
    18'b101_00000010_1_0_1_0_1_0_1, // R11 guard only
    18'b101_00000000_0_0_0_1_1_0_1, // R8 guard with pin low
    18'b010_00000000_0_0_1_0_0_0_1, // R3 disable allowed, hw off
    18'b101_11110100_1_0_1_0_0_0_1, // R9 lock set
    18'b101_00000000_1_0_0_1_0_0_1, // R9 locked
    18'b001_00000000_1_0_1_0_1_0_1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_good = 1'b0;
  logic          wp_n = 1'b1;
  logic          cmd_vld = 1'b0;
  logic [2:0]    cmd_kind = 3'd0;
  logic [PW-1:0] reg_wdata = '0;
  logic          op_done = 1'b0;
  logic          cmd_acc, cmd_rej, wel, quad_ok, read_only;
  logic [PW-1:0] prot_q;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  flash_wr_guard #(.HOLD_CYC(HOLD), .PROT_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wp_n(wp_n),
    .cmd_vld(cmd_vld), .cmd_kind(cmd_kind), .reg_wdata(reg_wdata),
    .op_done(op_done), .cmd_acc(cmd_acc), .cmd_rej(cmd_rej), .wel(wel),
    .quad_ok(quad_ok), .read_only(read_only), .prot_q(prot_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] k, input logic [PW-1:0] d,
                       input logic pin, input logic dn);
    wp_n = pin;
    repeat (3) @(negedge clk);
    cmd_vld = 1'b1; cmd_kind = k; reg_wdata = d; op_done = dn;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_kind = 3'd0; reg_wdata = '0; op_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset wel", {31'd0, wel}, 32'd0);
    chk("R1 reset verdict", {30'd0, cmd_acc, cmd_rej}, 32'd0);
    chk("R7 reset quad", {31'd0, quad_ok}, 32'd1);
    chk("R1 reset reg", {24'd0, prot_q}, 32'd0);

    pwr_good = 1'b1;
    apply(3'd1, '0, 1'b1, 1'b0);
    chk("R2 early enable rejected", {30'd0, cmd_acc, cmd_rej}, 32'd1);
    chk("R3 latch stays low", {31'd0, wel}, 32'd0);
    repeat (20) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] e;
      e = VEC[i];
      apply(e[17:15], e[14:7], e[6], e[5]);
      chk($sformatf("R10 vec%0d verdict", i), {30'd0, cmd_acc, cmd_rej}, {30'd0, e[4:3]});
      chk($sformatf("R3 vec%0d wel", i), {31'd0, wel}, {31'd0, e[2]});
      chk($sformatf("R6 vec%0d read_only", i), {31'd0, read_only}, {31'd0, e[1]});
      chk($sformatf("R7 vec%0d quad", i), {31'd0, quad_ok}, {31'd0, e[0]});
    end

    chk("R11 register contents", {24'd0, prot_q}, 32'h0000_00F4);
    apply(3'd5, 8'h00, 1'b1, 1'b0);
    chk("R9 locked write rejected", {30'd0, cmd_acc, cmd_rej}, 32'd1);
    @(negedge clk);
    chk("R10 reject lasts one cycle", {30'd0, cmd_acc, cmd_rej}, 32'd0);
    chk("R10 reject leaves register", {24'd0, prot_q}, 32'h0000_00F4);
    apply(3'd6, 8'h00, 1'b1, 1'b0);
    chk("R10 unused kind no pulse", {30'd0, cmd_acc, cmd_rej}, 32'd0);

    pwr_good = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 power loss wel", {31'd0, wel}, 32'd0);
    chk("R1 power loss reg", {24'd0, prot_q}, 32'd0);
    apply(3'd1, '0, 1'b1, 1'b0);
    chk("R1 strobe ignored unpowered", {30'd0, cmd_acc, cmd_rej}, 32'd0);

    pwr_good = 1'b1;
    apply(3'd1, '0, 1'b1, 1'b0);
    chk("R2 holdoff after return", {30'd0, cmd_acc, cmd_rej}, 32'd1);
    repeat (12) @(negedge clk);
    pwr_good = 1'b0;
    repeat (4) @(negedge clk);
    pwr_good = 1'b1;
    repeat (12) @(negedge clk);
    apply(3'd1, '0, 1'b1, 1'b0);
    chk("R2 count restarted", {30'd0, cmd_acc, cmd_rej}, 32'd1);
    repeat (20) @(negedge clk);
    apply(3'd5, 8'h01, 1'b1, 1'b0);
    chk("R9 lock cleared by power cycle", {30'd0, cmd_acc, cmd_rej}, 32'd2);
    chk("R7 quad off with hw enable, pin high", {31'd0, quad_ok}, 32'd0);

    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule